// File: doc/BRIEF.md
# Reset Supervisor with Manual-Reset Pulse Stretcher

This block generates the system reset for a board or a large chip from two causes. One is a power-good indication, which is high while the supply sits above its threshold. The other is a manual reset request arriving on a bidirectional reset pin that the block also drives. The pin is split into a sense input (`mr_in`) and a drive enable (`rst_oe`). An external pull resistor sets the pin's idle level. While the block asserts reset, it pulls the pin to its active level.

**Power loss.** Loss of power-good asserts reset at once, without waiting for a clock. When power-good returns, reset is held for a fixed interval and is then released.

**Manual reset.** A manual request counts only on a high-to-low transition of the pin. The pin must then stay low for a minimum number of clock cycles, so shorter glitches are discarded. Every accepted request produces a full-length reset interval, however short the press was.

**Self-masking.** The edge detector is masked while the block drives the pin. The pin is re-armed only after the pin has been seen high again. The block's own drive can therefore never start a new interval.

Both durations are parameters in clock cycles:
- `HOLD_CYC` is the reset interval.
- `MIN_LOW_CYC` is the glitch-rejection length.

Both polarities of the reset come from one internal state, so they change on the same edge.

Top module: `rst_supervisor`

## Requirements
- R1: While `power_good` is low, `rst_o`=1, `rst_n_o`=0 and `rst_oe`=1. This takes effect asynchronously, within the same time step as the fall of `power_good`, with no clock edge needed.
- R2: After `power_good` rises, reset stays asserted until the (HOLD_CYC+2)-th rising clock edge. It is released on that edge. This is two synchronizer edges plus HOLD_CYC counting edges.
- R3: A manual request is a high-to-low transition on `mr_in` (low = 0). The pin must then read low on MIN_LOW_CYC consecutive rising edges. Counting the first edge that sees it low as edge 1, reset asserts on edge MIN_LOW_CYC+3.
- R4: A low pulse on `mr_in` that spans fewer than MIN_LOW_CYC consecutive rising edges does not assert reset.
- R5: An accepted manual request keeps reset asserted for exactly HOLD_CYC clock cycles, independent of how long the pin was held low.
- R6: The pin staying low after the interval ends does not start a new interval, whether the low comes from the external source or from the block's own drive. A new request needs the pin to go high and then low again.
- R7: A loss of power-good during an active interval restarts the interval from zero. Reset is then released on the (HOLD_CYC+2)-th edge after `power_good` returns.
- R8: At every sampled cycle, `rst_n_o` is the inverse of `rst_o`, and `rst_oe` equals `rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| power_good | input | 1 | Supply-above-threshold flag, asynchronous; low clears the block |
| mr_in | input | 1 | Sensed level of the shared reset pin (1 = idle, 0 = pulled low) |
| rst_o | output | 1 | Active-high reset level |
| rst_n_o | output | 1 | Active-low reset level |
| rst_oe | output | 1 | Drive enable for the open-drain reset pads (1 = drive active level) |

## Verification
A wrong interval count shows directly as a reset pulse that is too long or too short. It is visible at `rst_oe` no later than HOLD_CYC+2 cycles after the triggering event. A broken glitch filter or arming state shows within MIN_LOW_CYC+3 cycles of a press: reset arrives late, early, for a too-short pulse, or not at all. Broken pin masking appears as a second reset immediately after the first is released, while the pin is still low. A missing restart on power loss shows as an early release after power returns.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    // Bits needed for a counter that runs 0 .. limit-1
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
    parameter int unsigned STAGES  = rst_sup_pkg::SYNC_STAGES,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rst_sup_filter.sv
module rst_sup_filter #(
    parameter int unsigned MIN_LOW_CYC = 20
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_s,
    input  logic mask,
    output logic fire
);

    localparam int unsigned FW = rst_sup_pkg::cnt_bits(MIN_LOW_CYC);

    typedef struct packed {
        logic          armed;
        logic [FW-1:0] cnt;
        logic          fire;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (mask) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (pin_s) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            if (st_q.cnt == FW'(MIN_LOW_CYC - 1)) begin
                st_d.fire  = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + FW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = st_q.fire;

    // R6: a request is a single-cycle pulse
    p_fire_single_r6: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.fire |=> !st_q.fire);

    // R6: the block's own drive never yields a request
    p_masked_no_fire_r6: assert property (@(posedge clk) disable iff (!arst_n)
        mask |=> !st_q.fire);

    // R4: a request only follows a low sample on the pin
    p_fire_after_low_r4: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(st_q.fire) |-> $past(!pin_s));

endmodule

// File: rtl/rst_sup_timer.sv
module rst_sup_timer #(
    parameter int unsigned HOLD_CYC = 40_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pg_s,
    input  logic press,
    output logic active
);

    localparam int unsigned CW = rst_sup_pkg::cnt_bits(HOLD_CYC);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pg_s || press) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == CW'(HOLD_CYC - 1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

    // R3: an accepted request starts a fresh interval
    p_start_on_press_r3: assert property (@(posedge clk) disable iff (!arst_n)
        (pg_s && press) |=> (st_q.active && st_q.cnt == '0));

    // R5: the interval is not cut short while counting
    p_hold_until_done_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (pg_s && !press && st_q.active && st_q.cnt < CW'(HOLD_CYC - 1)) |=> st_q.active);

    // R4: reset never starts without a cause
    p_no_spurious_start_r4: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(st_q.active) |-> ($past(press) || $past(!pg_s)));

    // R7: a synchronized power loss restarts the count
    p_power_restart_r7: assert property (@(posedge clk) disable iff (!arst_n)
        !pg_s |=> (st_q.active && st_q.cnt == '0));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned HOLD_CYC    = 40_000_000,
    parameter int unsigned MIN_LOW_CYC = 20
) (
    input  logic clk,
    input  logic power_good,
    input  logic mr_in,
    output logic rst_o,
    output logic rst_n_o,
    output logic rst_oe
);

    logic pg_s;
    logic mr_s;
    logic fire;
    logic active;

    // Reset synchronizer: cleared at once by power loss, released through the chain
    rst_sup_sync #(.RST_VAL(1'b0)) u_pg_sync (
        .clk    (clk),
        .arst_n (power_good),
        .din    (1'b1),
        .dout   (pg_s)
    );

    rst_sup_sync #(.RST_VAL(1'b1)) u_mr_sync (
        .clk    (clk),
        .arst_n (power_good),
        .din    (mr_in),
        .dout   (mr_s)
    );

    rst_sup_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filter (
        .clk    (clk),
        .arst_n (power_good),
        .pin_s  (mr_s),
        .mask   (active),
        .fire   (fire)
    );

    rst_sup_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .arst_n (power_good),
        .pg_s   (pg_s),
        .press  (fire),
        .active (active)
    );

    assign rst_o   = active;
    assign rst_n_o = ~active;
    assign rst_oe  = active;

    // R1: power loss always shows as an asserted reset at the next edge
    always_ff @(posedge clk) begin
        if (!power_good) begin
            p_pg_low_asserts_r1: assert (rst_oe && rst_o && !rst_n_o)
                else $error("reset not asserted while power_good low");
        end
    end

    // R6: the own drive on the pin does not re-trigger right after release
    p_no_self_retrigger_r6: assert property (@(posedge clk) disable iff (!power_good)
        $fell(active) |=> !active);

endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

    localparam int HOLD = 40;
    localparam int MINL = 5;

    logic clk = 1'b0;
    logic power_good;
    logic ext_low;
    logic mr_in;
    logic rst_o, rst_n_o, rst_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // shared pin: low when the outside pulls it or the block drives it
    assign mr_in = ~(ext_low | rst_oe);

    rst_supervisor #(.HOLD_CYC(HOLD), .MIN_LOW_CYC(MINL)) i_rst_supervisor (
        .clk        (clk),
        .power_good (power_good),
        .mr_in      (mr_in),
        .rst_o      (rst_o),
        .rst_n_o    (rst_n_o),
        .rst_oe     (rst_oe)
    );

    function automatic int exp_pwr_highs();
        return HOLD + 1;   // samples after power_good rises that still show reset
    endfunction

    function automatic int exp_first_hi();
        return MINL + 4;   // sample index of first asserted reset after a press
    endfunction

    function automatic bit exp_fires(input int len);
        return len >= MINL;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic check_pol();
        check((rst_n_o == ~rst_o) && (rst_oe == rst_o), "R8 polarity",
              {29'd0, rst_o, rst_n_o, rst_oe}, {29'd0, rst_o, ~rst_o, rst_o});
    endtask

    task automatic pwr_up(input string tag);
        int highs = 0;
        @(negedge clk);
        power_good = 1'b1;
        for (int k = 0; k < HOLD + 20; k++) begin
            @(negedge clk);
            check_pol();
            if (rst_oe) highs++;
        end
        check(highs == exp_pwr_highs(), tag, highs, exp_pwr_highs());
    endtask

    task automatic run_press(input int len, input int window);
        int first_hi = 0;
        int highs = 0;
        for (int k = 1; k <= window; k++) begin
            @(negedge clk);
            check_pol();
            if (rst_oe) begin
                highs++;
                if (first_hi == 0) first_hi = k;
            end
            ext_low = (k <= len);
        end
        @(negedge clk);
        ext_low = 1'b0;
        repeat (6) @(negedge clk);
        if (exp_fires(len)) begin
            check(first_hi == exp_first_hi(), "R3 latency", first_hi, exp_first_hi());
            check(highs == HOLD, "R5 duration", highs, HOLD);
        end else begin
            check(highs == 0, "R4 glitch ignored", highs, 0);
        end
    endtask

    initial begin
        power_good = 1'b1;
        ext_low    = 1'b0;
        #1 power_good = 1'b0;
        #0.5;
        check(rst_oe && rst_o && !rst_n_o, "R1 async assert", rst_oe, 1);
        repeat (4) @(negedge clk);
        check(rst_oe == 1'b1, "R1 held while low", rst_oe, 1);
        check_pol();

        pwr_up("R2 power-up hold");
        repeat (6) @(negedge clk);

        // directed corner cases
        run_press(MINL, MINL + HOLD + 12);
        run_press(MINL - 1, MINL + HOLD + 12);
        run_press(1, MINL + HOLD + 12);
        run_press(MINL + 1, MINL + HOLD + 12);

        // R6: hold the pin low far past the interval
        begin
            int first_hi = 0;
            int highs = 0;
            int len = MINL + HOLD + 30;
            for (int k = 1; k <= len + 20; k++) begin
                @(negedge clk);
                check_pol();
                if (rst_oe) begin
                    highs++;
                    if (first_hi == 0) first_hi = k;
                end
                ext_low = (k <= len);
            end
            check(first_hi == exp_first_hi(), "R6 long press start", first_hi, exp_first_hi());
            check(highs == HOLD, "R6 no retrigger while low", highs, HOLD);
            repeat (6) @(negedge clk);
        end

        // random pulse lengths
        void'($urandom(32'd1234));
        for (int i = 0; i < 30; i++) begin
            int len = $urandom_range(1, 2 * MINL);
            run_press(len, MINL + HOLD + 12);
        end

        // R7: power loss in the middle of a manual interval
        for (int k = 1; k <= MINL + 14; k++) begin
            @(negedge clk);
            ext_low = (k <= MINL);
        end
        check(rst_oe == 1'b1, "R7 interval active", rst_oe, 1);
        @(negedge clk);
        power_good = 1'b0;
        #1;
        check(rst_oe == 1'b1, "R1 async during interval", rst_oe, 1);
        repeat (3) @(negedge clk);
        pwr_up("R7 restart after power loss");
        repeat (6) @(negedge clk);

        // pin usable again after recovery
        run_press(MINL, MINL + HOLD + 12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule